// File: doc/BRIEF.md
# Four-Lane Receive Termination Checker

This block sits after the lane deskew stage of a four-lane receiver. Every clock it sees one column: one byte per lane, a control flag per lane, and a flag per lane from the line decoder saying that the received code group could not be decoded. It finds packet terminations that are not followed by proper idle fill, and it counts them per lane. It also counts undecodable code groups per lane.

There are eight 16-bit counters: four for bad terminations and four for code errors. They share a set of rules. Each counter starts at 0xFFFD after reset. It advances by one per event, and only while the lanes report alignment. It stops at 0xFFFF. A read through the small register port returns its value and then clears it. Host software polls the counters to watch link quality.

Top module: `rx_term_monitor`

## Requirements
- R1: A terminate (byte 0xFD with the control flag set) in lane k is flagged as an error for lane k when any higher-numbered lane in the same column is not an idle /K/ (byte 0xBC with the control flag set). Lane 0 looks at lanes 1 to 3, lane 1 at lanes 2 and 3, lane 2 at lane 3, and lane 3 has no such condition.
- R2: A terminate in lane k is also flagged as an error for lane k when the next column is neither all /K/ nor all /A/ (byte 0x7C with the control flag set). A byte whose control flag is clear never counts as a control code.
- R3: The code-error counter of a lane advances when that lane's decode-error flag is high in a cycle.
- R4: A counter advances only in a cycle where lanes_aligned is high. While it is low, the counter holds its value. For a termination, alignment is sampled in the cycle of the following column.
- R5: A counter saturates at 0xFFFF and never wraps.
- R6: After reset every counter holds 0xFFFD and rd_data is 0.
- R7: A read strobe with address a loads rd_data with counter a on the next clock and clears that counter. Addresses 0 to 3 select the termination counters of lanes 0 to 3, and 4 to 7 select the code-error counters of lanes 0 to 3. rd_data holds its value between reads.
- R8: When an event arrives for a counter in the same cycle that the counter is read, the read returns the old value and the counter becomes 1.
- R9: Lanes are judged independently. Each error adds exactly one to its own lane's counter only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Column bytes; lane n in bits 8n+7:8n |
| rx_ctrl | input | 4 | Control flag per lane |
| rx_derr | input | 4 | Decode-error flag per lane |
| lanes_aligned | input | 1 | Lanes are deskewed; enables counting |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Counter select |
| rd_data | output | 16 | Counter value, valid one clock after the strobe |

## Verification
A termination is judged when the column after it arrives, so its counter changes on the clock edge that captures that following column, two edges after the terminate column is driven. A code error changes its counter on the edge that captures it. rd_data changes on the edge that captures the strobe. The bench drives every input on the falling edge and samples rd_data on the next falling edge after the read edge. Before reading, it always lets one idle column pass after a judged column, so each result is complete when it is sampled.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  localparam logic [7:0] CODE_TERM = 8'hFD;
  localparam logic [7:0] CODE_IDLE = 8'hBC;
  localparam logic [7:0] CODE_ALGN = 8'h7C;

  function automatic logic is_code(input logic [7:0] b, input logic c, input logic [7:0] code);
    return c && (b == code);
  endfunction
endpackage

// File: rtl/rxt_term_judge.sv
module rxt_term_judge
  import rxt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] col_data,
  input  logic [LANES-1:0]   col_ctrl,
  output logic [LANES-1:0]   eop_err
);
  logic [LANES-1:0] term_hit, tail_bad, is_idle, is_algn;
  logic [LANES-1:0] term_q, tail_bad_q;
  logic             col_ok;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign term_hit[g] = is_code(col_data[g*8 +: 8], col_ctrl[g], CODE_TERM);
      assign is_idle[g]  = is_code(col_data[g*8 +: 8], col_ctrl[g], CODE_IDLE);
      assign is_algn[g]  = is_code(col_data[g*8 +: 8], col_ctrl[g], CODE_ALGN);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      tail_bad[i] = 1'b0;
      for (int j = i + 1; j < LANES; j++)
        if (!is_idle[j]) tail_bad[i] = 1'b1;
    end
  end

  assign col_ok = (&is_idle) | (&is_algn);

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q     <= '0;
      tail_bad_q <= '0;
    end else begin
      term_q     <= term_hit;
      tail_bad_q <= tail_bad;
    end
  end

  assign eop_err = term_q & (tail_bad_q | {LANES{~col_ok}});

  generate
    for (g = 0; g < LANES; g++) begin : g_chk
      assert_err_needs_term_R1: assert property (@(posedge clk) disable iff (rst)
        eop_err[g] |-> $past(col_ctrl[g] && col_data[g*8 +: 8] == CODE_TERM));
    end
  endgenerate
  assert_clean_tail_R2: assert property (@(posedge clk) disable iff (rst)
    (col_ok && !$past(|tail_bad)) |-> (eop_err == '0));
endmodule

// File: rtl/rxt_sat_cnt.sv
module rxt_sat_cnt #(
  parameter int          CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_in,
  input  logic             enable,
  input  logic             clear,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic step;
  assign step = event_in & enable;

  always_ff @(posedge clk) begin
    if (rst)                           value <= RST_VAL;
    else if (clear)                    value <= step ? ONE : '0;
    else if (step && value != MAX_VAL) value <= value + ONE;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (value == MAX_VAL && !clear) |=> value == MAX_VAL);
  assert_hold_unaligned_R4: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clear) |=> $stable(value));
  assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (value == $past(value) || value == $past(value) + ONE));
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    (clear && !step) |=> value == '0);
  assert_keep_event_R8: assert property (@(posedge clk) disable iff (rst)
    (clear && step) |=> value == ONE);
endmodule

// File: rtl/rx_term_monitor.sv
module rx_term_monitor
  import rxt_pkg::*;
#(
  parameter int               LANES   = 4,
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFD,
  localparam int              NCNT    = 2 * LANES,
  localparam int              AW      = $clog2(NCNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] rx_data,
  input  logic [LANES-1:0]   rx_ctrl,
  input  logic [LANES-1:0]   rx_derr,
  input  logic               lanes_aligned,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [CNT_W-1:0]   rd_data
);
  logic [LANES-1:0] eop_err;
  logic [NCNT-1:0]  events, clears;
  logic [CNT_W-1:0] cnt [NCNT];

  rxt_term_judge #(.LANES(LANES)) u_judge (
    .clk(clk), .rst(rst), .col_data(rx_data), .col_ctrl(rx_ctrl), .eop_err(eop_err)
  );

  assign events = {rx_derr, eop_err};

  genvar g;
  generate
    for (g = 0; g < NCNT; g++) begin : g_cnt
      assign clears[g] = rd_en && (rd_addr == AW'(g));
      rxt_sat_cnt #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
        .clk(clk), .rst(rst), .event_in(events[g]), .enable(lanes_aligned),
        .clear(clears[g]), .value(cnt[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= cnt[rd_addr];
  end

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(cnt[rd_addr]));
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_one_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clears));
endmodule

// File: tb/test_rx_term_monitor.sv
module test_rx_term_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam logic [31:0] KCOL = 32'hBCBCBCBC;
  localparam logic [31:0] ACOL = 32'h7C7C7C7C;
  // {first column data, ctrl, next column data, ctrl, expected eop lane mask}
  localparam logic [75:0] VEC [NV] = '{
    {32'hBCBCBCFD, 4'hF, KCOL,         4'hF, 4'h0},
    {32'hBCBCBCFD, 4'hF, ACOL,         4'hF, 4'h0},
    {32'hBCBCBCFD, 4'hF, 32'h7C7CBCBC, 4'hF, 4'h1},
    {32'hBCBCFD55, 4'hE, KCOL,         4'hF, 4'h0},
    {32'hBC7CFD55, 4'hE, KCOL,         4'hF, 4'h2},
    {32'h55BCFD55, 4'h6, KCOL,         4'hF, 4'h2},
    {32'hBCFD5555, 4'hC, ACOL,         4'hF, 4'h0},
    {32'h55FD5555, 4'h4, KCOL,         4'hF, 4'h4},
    {32'hFD555555, 4'h8, KCOL,         4'hF, 4'h0},
    {32'hFD555555, 4'h8, KCOL,         4'h7, 4'h8},
    {32'hBCBCBCFD, 4'hF, 32'h55555555, 4'h0, 4'h1},
    {32'hBCBCFDFD, 4'hF, KCOL,         4'hF, 4'h1},
    {32'h555555FD, 4'h0, 32'h55555555, 4'h0, 4'h0},
    {32'hBCBCBCFD, 4'hF, 32'h7C7C7CBC, 4'hF, 4'h1}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] rx_data = KCOL;
  logic [3:0]  rx_ctrl = 4'hF, rx_derr = 4'h0;
  logic        lanes_aligned = 1'b1, rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  int n_cmp = 0, n_bad = 0;

  rx_term_monitor i_rx_term_monitor (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_derr(rx_derr),
    .lanes_aligned(lanes_aligned), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic col(input logic [31:0] d, input logic [3:0] c, input logic [3:0] e);
    @(negedge clk);
    rx_data = d; rx_ctrl = c; rx_derr = e;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rx_data = KCOL; rx_ctrl = 4'hF; rx_derr = 4'h0;
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; rx_data = KCOL; rx_ctrl = 4'hF; rx_derr = 4'h0;
    lanes_aligned = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R6 rd_data after reset", rd_data, 16'h0000);
    for (int a = 0; a < 8; a++) rd(3'(a), 16'hFFFD, "R6 reset value");

    // table walk: every counter is clear on entry
    for (int v = 0; v < NV; v++) begin
      col(KCOL, 4'hF, 4'h0);
      col(VEC[v][75:44], VEC[v][43:40], 4'h0);
      col(VEC[v][39:8],  VEC[v][7:4],   4'h0);
      col(KCOL, 4'hF, 4'h0);
      for (int l = 0; l < 4; l++)
        rd(3'(l), {15'h0, VEC[v][l]}, $sformatf("R1 R2 R9 vec %0d lane %0d", v, l));
    end

    // code errors per lane, independent
    col(KCOL, 4'hF, 4'b0101);
    col(KCOL, 4'hF, 4'b0100);
    rd(3'd4, 16'd1, "R3 code lane 0");
    rd(3'd5, 16'd0, "R3 R9 code lane 1");
    rd(3'd6, 16'd2, "R3 code lane 2");
    rd(3'd7, 16'd0, "R3 R9 code lane 3");

    // alignment gating and hold
    lanes_aligned = 1'b0;
    col(KCOL, 4'hF, 4'b1000);
    col(KCOL, 4'hF, 4'b1000);
    col(KCOL, 4'hF, 4'h0);
    lanes_aligned = 1'b1;
    rd(3'd7, 16'd0, "R4 code gated");
    col(KCOL, 4'hF, 4'b0100);
    col(KCOL, 4'hF, 4'b0100);
    col(KCOL, 4'hF, 4'h0); lanes_aligned = 1'b0;
    col(KCOL, 4'hF, 4'b0100);
    col(KCOL, 4'hF, 4'b0100);
    col(KCOL, 4'hF, 4'h0); lanes_aligned = 1'b1;
    rd(3'd6, 16'd2, "R4 hold while unaligned");
    col(32'hBCBCBCFD, 4'hF, 4'h0);
    col(32'h55555555, 4'h0, 4'h0); lanes_aligned = 1'b0;
    col(KCOL, 4'hF, 4'h0); lanes_aligned = 1'b1;
    rd(3'd0, 16'd0, "R4 eop gated at judge cycle");

    // read collides with an event
    col(KCOL, 4'hF, 4'b0001);
    col(KCOL, 4'hF, 4'b0001);
    col(KCOL, 4'hF, 4'b0001);
    @(negedge clk);
    rx_derr = 4'b0001; rd_en = 1'b1; rd_addr = 3'd4;
    @(negedge clk);
    rd_en = 1'b0; rx_derr = 4'h0;
    check("R8 collision returns old", rd_data, 16'd3);
    col(KCOL, 4'hF, 4'h0);
    check("R7 rd_data holds", rd_data, 16'd3);
    rd(3'd4, 16'd1, "R8 collision keeps event");
    rd(3'd4, 16'd0, "R7 cleared after read");

    // saturation
    do_reset();
    for (int k = 0; k < 4; k++) col(KCOL, 4'hF, 4'b0010);
    for (int k = 0; k < 3; k++) begin
      col(32'hBCBCBCFD, 4'hF, 4'h0);
      col(32'h55555555, 4'h0, 4'h0);
    end
    col(KCOL, 4'hF, 4'h0);
    rd(3'd5, 16'hFFFF, "R5 code saturate");
    rd(3'd0, 16'hFFFF, "R5 eop saturate");
    rd(3'd1, 16'hFFFD, "R9 untouched lane");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule